// File: doc/BRIEF.md
# Dual-Clock Mailbox Register with Occupancy Flag

This block carries a single data word from a writer clock domain to a reader clock domain. It sits beside a FIFO but is not part of the FIFO's data path. When the writer stores a word, an active-low flag in the writer domain goes low. While that flag is low, the writer cannot store another word. The reader sees a mail-valid indication once the write has crossed into its domain. When the reader consumes the word, the flag returns high in the writer domain after a synchronizer delay.

The reader's data output is a multiplexer. A select input chooses between the mailbox word and a FIFO output word that arrives on its own input. Toggle bits carry the handshake between the domains, and each toggle passes through a chain of synchronizer flops. Both resets assert asynchronously and release synchronously in each domain. The master reset also clears the stored word. The partial reset keeps the stored word and clears only the handshake state.

Top module: `mbx_dual_clk`

## Requirements
- R1: A rising `wr_clk` edge with `wr_en` high and `mbx_free_n` high loads `wr_data` into the mailbox. `mbx_free_n` is low from that edge onward.
- R2: While `mbx_free_n` is low, `wr_en` has no effect. The stored word stays the same, and the reader later sees the first word.
- R3: After an accepted write, `mail_valid` goes high within SYNC_STAGES+1 rising edges of `rd_clk`.
- R4: A rising `rd_clk` edge with `rd_en`, `rd_sel` and `mail_valid` all high consumes the word. `mail_valid` is low after that edge, and `mbx_free_n` returns high within SYNC_STAGES+2 rising edges of `wr_clk`.
- R5: A read with `rd_sel` low, or a read while `mail_valid` is low, changes no state. `mail_valid` and `mbx_free_n` keep their values.
- R6: `rd_sel` high (value 1) puts the mailbox word on `rd_data`. `rd_sel` low (value 0) puts `fifo_q` on `rd_data`.
- R7: A master reset (`mst_rst_n` low) forces `mbx_free_n` high and `mail_valid` low, and it clears the stored word to zero.
- R8: A partial reset (`prt_rst_n` low) forces `mbx_free_n` high and `mail_valid` low, but it keeps the stored word.
- R9: Reset takes effect asynchronously. `mbx_free_n` is high while a reset is low, even before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer clock |
| wr_en | input | 1 | Mailbox write request |
| wr_data | input | DATA_W | Word to store |
| mbx_free_n | output | 1 | Low while the mailbox holds an unconsumed word |
| rd_clk | input | 1 | Reader clock |
| rd_en | input | 1 | Read request |
| rd_sel | input | 1 | 1 selects the mailbox, 0 selects the FIFO word |
| fifo_q | input | DATA_W | FIFO output register word |
| rd_data | output | DATA_W | Selected output word |
| mail_valid | output | 1 | Reader-domain indication that a word is waiting |
| mst_rst_n | input | 1 | Master reset, active low, asynchronous |
| prt_rst_n | input | 1 | Partial reset, active low, asynchronous |

## Verification
The writer and reader clocks run at unrelated periods, so every handshake crosses a real phase drift. A stream of distinct words goes through the scoreboard with the reader consuming automatically. This shows whether words are lost or duplicated, or whether the flag fails to re-open.

Three targeted patterns separate ignored stimulus from accepted stimulus:
- a write while the flag is low,
- a read with the FIFO selected,
- a read with no mail waiting.

A word is left pending across each reset kind. This shows the difference between clearing the stored word (master reset) and retaining it (partial reset).

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // Output select encoding shared by the mux and the bench-facing docs
   typedef enum logic {
      SEL_FIFO = 1'b0,
      SEL_MAIL = 1'b1
   } mbx_sel_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RST_VAL;
            else        chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n
);
   // Assert at once, release after STAGES clock edges
   mbx_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_chain (
      .clk   (clk),
      .rst_n (arst_n),
      .d     (1'b1),
      .q     (rst_n)
   );
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side #(
   parameter int DATA_W = 36,
   parameter int STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rst_all_n,
   input  logic              rst_mst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ack_tog_async,
   output logic [DATA_W-1:0] mbox_q,
   output logic              wr_tog,
   output logic              free_n
);
   logic ack_tog_s;
   logic accept;

   mbx_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk   (wr_clk),
      .rst_n (rst_all_n),
      .d     (ack_tog_async),
      .q     (ack_tog_s)
   );

   // Occupied while the write toggle leads the returned acknowledge
   assign free_n = ~(wr_tog ^ ack_tog_s);
   assign accept = wr_en & free_n & rst_all_n;

   always_ff @(posedge wr_clk or negedge rst_all_n) begin
      if (!rst_all_n)  wr_tog <= 1'b0;
      else if (accept) wr_tog <= ~wr_tog;
   end

   // Stored word survives a partial reset, cleared only by master reset
   always_ff @(posedge wr_clk or negedge rst_mst_n) begin
      if (!rst_mst_n)  mbox_q <= '0;
      else if (accept) mbox_q <= wr_data;
   end
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side #(
   parameter int STAGES = 2
) (
   input  logic rd_clk,
   input  logic rst_n,
   input  logic wr_tog_async,
   input  logic rd_en,
   input  logic rd_sel,
   output logic valid,
   output logic rd_tog
);
   logic wr_tog_s;
   logic consume;

   mbx_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_wr_sync (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wr_tog_async),
      .q     (wr_tog_s)
   );

   assign valid   = wr_tog_s ^ rd_tog;
   assign consume = rd_en & rd_sel & valid;

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)       rd_tog <= 1'b0;
      else if (consume) rd_tog <= ~rd_tog;
   end
endmodule

// File: rtl/mbx_dual_clk.sv
module mbx_dual_clk #(
   parameter int DATA_W      = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              mbx_free_n,
   input  logic              rd_clk,
   input  logic              rd_en,
   input  logic              rd_sel,
   input  logic [DATA_W-1:0] fifo_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              mail_valid,
   input  logic              mst_rst_n,
   input  logic              prt_rst_n
);
   import mbx_pkg::*;

   if (DATA_W < 1) begin : g_bad_width
      $error("mbx_dual_clk: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("mbx_dual_clk: SYNC_STAGES must be at least 2");
   end

   logic              any_rst_n;
   logic              wr_rst_n;
   logic              wr_mst_n;
   logic              rd_rst_n;
   logic              wr_tog;
   logic              rd_tog;
   logic [DATA_W-1:0] mbox_q;
   mbx_sel_e          sel;

   assign any_rst_n = mst_rst_n & prt_rst_n;

   mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
      .clk (wr_clk), .arst_n (any_rst_n), .rst_n (wr_rst_n)
   );
   mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_mst (
      .clk (wr_clk), .arst_n (mst_rst_n), .rst_n (wr_mst_n)
   );
   mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
      .clk (rd_clk), .arst_n (any_rst_n), .rst_n (rd_rst_n)
   );

   mbx_wr_side #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_wr (
      .wr_clk        (wr_clk),
      .rst_all_n     (wr_rst_n),
      .rst_mst_n     (wr_mst_n),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .ack_tog_async (rd_tog),
      .mbox_q        (mbox_q),
      .wr_tog        (wr_tog),
      .free_n        (mbx_free_n)
   );

   mbx_rd_side #(.STAGES(SYNC_STAGES)) u_rd (
      .rd_clk       (rd_clk),
      .rst_n        (rd_rst_n),
      .wr_tog_async (wr_tog),
      .rd_en        (rd_en),
      .rd_sel       (rd_sel),
      .valid        (mail_valid),
      .rd_tog       (rd_tog)
   );

   assign sel     = mbx_sel_e'(rd_sel);
   assign rd_data = (sel == SEL_MAIL) ? mbox_q : fifo_q;
endmodule

// File: rtl/mbx_dual_clk_chk.sv
module mbx_dual_clk_chk #(
   parameter int DATA_W = 36
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              mbx_free_n,
   input logic              rd_en,
   input logic              rd_sel,
   input logic              mail_valid,
   input logic [DATA_W-1:0] mbox_q,
   input logic              wr_rst_n,
   input logic              rd_rst_n
);
   // R1
   wr_accept_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_en && mbx_free_n) |=> (!mbx_free_n && mbox_q == $past(wr_data)));

   // R2
   wr_blocked_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_en && !mbx_free_n) |=> $stable(mbox_q));

   // R4
   consume_clears_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_en && rd_sel && mail_valid) |=> !mail_valid);

   // R5
   valid_holds_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (mail_valid && !(rd_en && rd_sel)) |=> mail_valid);

   // R4
   valid_implies_busy_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n || !wr_rst_n)
      mail_valid |-> !mbx_free_n);
endmodule

bind mbx_dual_clk mbx_dual_clk_chk #(.DATA_W(DATA_W)) u_chk (
   .wr_clk     (wr_clk),
   .rd_clk     (rd_clk),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .mbx_free_n (mbx_free_n),
   .rd_en      (rd_en),
   .rd_sel     (rd_sel),
   .mail_valid (mail_valid),
   .mbox_q     (mbox_q),
   .wr_rst_n   (wr_rst_n),
   .rd_rst_n   (rd_rst_n)
);

// File: tb/sim_mbx_dual_clk.sv
module sim_mbx_dual_clk;
   localparam int CLK_PERIOD = 10;
   localparam int RD_PERIOD  = CLK_PERIOD + 4;
   localparam int DW         = 36;
   localparam int SYNC       = 2;

   logic          wr_clk = 1'b0, rd_clk = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
   logic [DW-1:0] wr_data = '0, fifo_q = '0, rd_data;
   logic          mbx_free_n, mail_valid;
   logic          mst_rst_n = 1'b1, prt_rst_n = 1'b1;
   logic          auto_rd = 1'b0;
   int            checks = 0, errors = 0;
   logic [DW-1:0] expq [$];

   always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
   always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

   mbx_dual_clk #(.DATA_W(DW), .SYNC_STAGES(SYNC)) u0 (
      .wr_clk, .wr_en, .wr_data, .mbx_free_n, .rd_clk, .rd_en, .rd_sel,
      .fifo_q, .rd_data, .mail_valid, .mst_rst_n, .prt_rst_n
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [DW-1:0] w);
      while (!mbx_free_n) @(negedge wr_clk);
      wr_en = 1'b1; wr_data = w;
      expq.push_back(w);
      @(negedge wr_clk);
      wr_en = 1'b0;
   endtask

   // Monitor: pops and compares whenever automatic reading is on
   initial forever begin
      @(negedge rd_clk);
      if (auto_rd) begin
         if (rd_en) rd_en = 1'b0;
         else if (mail_valid) begin
            rd_sel = 1'b1; #1;
            if (expq.size() == 0) chk(1'b0, "R4 unexpected word", rd_data, '0);
            else begin
               logic [DW-1:0] e;
               e = expq.pop_front();
               chk(rd_data == e, "R6 stream word", rd_data, e);
            end
            rd_en = 1'b1;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      logic [DW-1:0] p;
      #1 mst_rst_n = 1'b0;
      #1;
      // R9: asynchronous assertion before any clock edge
      chk(mbx_free_n == 1'b1, "R9 flag in reset", DW'(mbx_free_n), 1);
      repeat (4) @(negedge rd_clk);
      mst_rst_n = 1'b1;
      repeat (6) @(negedge wr_clk);
      rd_sel = 1'b1; #1;
      // R7: cleared word and idle flags after master reset
      chk(rd_data == '0, "R7 word after reset", rd_data, '0);
      chk(mail_valid == 1'b0, "R7 valid after reset", DW'(mail_valid), 0);

      // R1: accepted write drives flag low
      @(negedge wr_clk);
      chk(mbx_free_n == 1'b1, "R1 flag before write", DW'(mbx_free_n), 1);
      wr_en = 1'b1; wr_data = 36'hA_1234_5678;
      @(negedge wr_clk);
      wr_en = 1'b0;
      chk(mbx_free_n == 1'b0, "R1 flag after write", DW'(mbx_free_n), 0);

      // R2: write while occupied is ignored
      wr_en = 1'b1; wr_data = 36'hC_0000_FFFF;
      @(negedge wr_clk);
      wr_en = 1'b0;
      chk(mbx_free_n == 1'b0, "R2 flag stays low", DW'(mbx_free_n), 0);

      // R3: valid appears after synchronizer delay
      n = 0;
      while (!mail_valid && n < 10) begin @(negedge rd_clk); n++; end
      chk(mail_valid && n <= SYNC + 1, "R3 valid latency", DW'(n), SYNC + 1);

      // R6 and R2: mailbox word is the first one; FIFO side selectable
      rd_sel = 1'b1; #1;
      chk(rd_data == 36'hA_1234_5678, "R2 R6 mailbox word", rd_data, 36'hA_1234_5678);
      rd_sel = 1'b0; fifo_q = 36'h5_5AA5_0F0F; #1;
      chk(rd_data == 36'h5_5AA5_0F0F, "R6 fifo word", rd_data, 36'h5_5AA5_0F0F);

      // R5: read with FIFO selected consumes nothing
      @(negedge rd_clk); rd_en = 1'b1; rd_sel = 1'b0;
      @(negedge rd_clk); rd_en = 1'b0;
      chk(mail_valid == 1'b1, "R5 valid kept on fifo read", DW'(mail_valid), 1);
      chk(mbx_free_n == 1'b0, "R5 flag kept on fifo read", DW'(mbx_free_n), 0);

      // R4: consume, then flag returns
      rd_en = 1'b1; rd_sel = 1'b1;
      @(negedge rd_clk); rd_en = 1'b0;
      chk(mail_valid == 1'b0, "R4 valid cleared", DW'(mail_valid), 0);
      n = 0;
      while (!mbx_free_n && n < 10) begin @(negedge wr_clk); n++; end
      chk(mbx_free_n && n <= SYNC + 2, "R4 flag release latency", DW'(n), SYNC + 2);

      // R5: read with no mail waiting changes nothing
      @(negedge rd_clk); rd_en = 1'b1; rd_sel = 1'b1;
      @(negedge rd_clk); rd_en = 1'b0;
      repeat (6) @(negedge wr_clk);
      chk(mbx_free_n == 1'b1, "R5 flag after empty read", DW'(mbx_free_n), 1);
      chk(mail_valid == 1'b0, "R5 valid after empty read", DW'(mail_valid), 0);

      // Scoreboard stream with automatic reader
      auto_rd = 1'b1;
      for (int i = 0; i < 8; i++) send(DW'(36'h1_0000_0000 + i * 36'h0_1111_1111));
      n = 0;
      while ((expq.size() != 0 || !mbx_free_n) && n < 400) begin @(negedge wr_clk); n++; end
      chk(expq.size() == 0 && mbx_free_n, "R4 stream drained", DW'(expq.size()), 0);
      @(negedge rd_clk); @(negedge rd_clk);
      auto_rd = 1'b0; rd_en = 1'b0;

      // R8: partial reset keeps the word, clears handshake
      p = 36'h9_8765_4321;
      send(p);
      void'(expq.pop_back());
      repeat (6) @(negedge rd_clk);
      prt_rst_n = 1'b0; #1;
      chk(mbx_free_n == 1'b1, "R8 flag in partial reset", DW'(mbx_free_n), 1);
      chk(mail_valid == 1'b0, "R8 valid in partial reset", DW'(mail_valid), 0);
      repeat (4) @(negedge rd_clk);
      prt_rst_n = 1'b1;
      repeat (6) @(negedge rd_clk);
      rd_sel = 1'b1; #1;
      chk(rd_data == p, "R8 word retained", rd_data, p);
      chk(mail_valid == 1'b0, "R8 valid after partial reset", DW'(mail_valid), 0);

      // R7: master reset with a word pending clears it
      send(36'h3_3333_3333);
      void'(expq.pop_back());
      repeat (6) @(negedge rd_clk);
      mst_rst_n = 1'b0;
      repeat (4) @(negedge rd_clk);
      mst_rst_n = 1'b1;
      repeat (6) @(negedge rd_clk);
      rd_sel = 1'b1; #1;
      chk(rd_data == '0, "R7 word cleared", rd_data, '0);
      chk(mbx_free_n == 1'b1, "R7 flag after master reset", DW'(mbx_free_n), 1);
      chk(mail_valid == 1'b0, "R7 valid after master reset", DW'(mail_valid), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule